// File: doc/BRIEF.md
# SPI Framed Memory-Mapped Bridge

This block is an SPI slave that turns framed serial transactions into byte-wide register accesses inside the chip. A frame lasts while slave select is held low. The first two bytes form a 16-bit header. Its top bit selects a write or a read, and the remaining fifteen bits give a starting address. Every byte after the header is payload. In a write frame, each payload byte goes to the current address. In a read frame, each payload byte period returns the byte stored at the current address.

The address space is split in two. Addresses below 0x100 reach a small local control-register port. Addresses at or above 0x100 reach a user-logic port, and the bridge subtracts 0x100 before presenting them, so the user logic sees an address space that starts at zero. The address advances by one after each payload byte, and a single frame may cross from the local region into the user region.

The serial lines run in SPI mode 0 with the most significant bit first. All three inputs are brought into the system clock domain through two-flop synchronisers, and the system clock must run at least eight times faster than SCLK. Both ports return read data one system clock cycle after the read strobe.

Top module: `spi_mm_bridge`

## Requirements
- R1: Raising slave select ends the frame. A partial header or a partial byte is then discarded: it causes no write and no read, and the next frame starts again with a fresh header.
- R2: The header is received most significant byte first. Header bit 15 set to 1 marks a write frame and 0 marks a read frame. Bits 14..0 give the start address.
- R3: An access to an address from 0x000 to 0x0FF appears on the local port. The local address is the low 8 bits of the address, and the user port is not strobed.
- R4: An access to an address of 0x100 or above appears on the user port with an address equal to the frame address minus 0x100. The local port is not strobed.
- R5: In a write frame, each complete payload byte produces exactly one write strobe, one system clock cycle long, carrying that byte as data.
- R6: After each payload byte the address goes up by one, so consecutive payload bytes reach consecutive locations, and this continues across the 0x0FF/0x100 boundary.
- R7: In a read frame, one read strobe is issued at the start address as soon as the header is complete. The returned byte is shifted out on MISO, most significant bit first, during the first payload byte period.
- R8: In a read frame, each payload byte period increments the address and issues one further read. A frame with N payload bytes therefore makes N+1 read strobes, and its N bytes come from consecutive addresses.
- R9: At most one of the four strobes (local write, local read, user write, user read) is active in any cycle.
- R10: After reset no strobe is active and MISO is low. MISO stays low throughout the header and throughout write frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI serial clock (mode 0) |
| mosi | input | 1 | Serial data from the master |
| ss_n | input | 1 | Active-low slave select, frames a transaction |
| miso | output | 1 | Serial data to the master |
| loc_wr | output | 1 | Local register write strobe |
| loc_rd | output | 1 | Local register read strobe |
| loc_addr | output | 8 | Local register address |
| loc_wdata | output | 8 | Local write data |
| loc_rdata | input | 8 | Local read data, valid one cycle after loc_rd |
| usr_wr | output | 1 | User logic write strobe |
| usr_rd | output | 1 | User logic read strobe |
| usr_addr | output | 15 | User address with the 0x100 base removed |
| usr_wdata | output | 8 | User write data |
| usr_rdata | input | 8 | User read data, valid one cycle after usr_rd |

## Verification
The assertions rely on SCLK being at least eight times slower than the system clock and on slave select rising only after the final SCLK edge has settled. Under these conditions two payload bytes always complete many cycles apart, and no strobe is still pending when a frame closes. The bench master keeps SCLK at sixteen system clocks per period and holds slave select for several cycles after the last falling edge. Its one deliberate violation is the aborted frame, which raises slave select in the middle of a byte. Random frames are confined to addresses 0x000 to 0x1FF so that the bench's memory models cover every location that can be reached.

// File: rtl/spi_mm_bridge.sv
module spi_mm_bridge #(
  parameter int HDR_AW   = 15,
  parameter int USR_BASE = 256
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sclk,
  input  logic                  mosi,
  input  logic                  ss_n,
  output logic                  miso,
  output logic                  loc_wr,
  output logic                  loc_rd,
  output logic [7:0]            loc_addr,
  output logic [7:0]            loc_wdata,
  input  logic [7:0]            loc_rdata,
  output logic                  usr_wr,
  output logic                  usr_rd,
  output logic [HDR_AW-1:0]     usr_addr,
  output logic [7:0]            usr_wdata,
  input  logic [7:0]            usr_rdata
);
  localparam int LOC_AW = $clog2(USR_BASE);
  localparam logic [HDR_AW-1:0] BASE = HDR_AW'(USR_BASE);

  logic [2:0] sclk_sy, ss_sy;
  logic [1:0] mosi_sy;
  logic [2:0] bit_cnt;
  logic [6:0] in_sr;
  logic [7:0] out_sr, wdata;
  logic [1:0] byte_idx;
  logic       is_wr, wr_q, rd_q, rd_dly;
  logic [HDR_AW-1:0] addr;

  wire active    = ~ss_sy[1];
  wire sclk_rise = sclk_sy[1] & ~sclk_sy[2];
  wire sclk_fall = ~sclk_sy[1] & sclk_sy[2];
  wire byte_done = active & sclk_rise & (bit_cnt == 3'd7);
  wire [7:0] rx  = {in_sr, mosi_sy[1]};
  wire in_usr    = addr >= BASE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sy <= '0;
      ss_sy   <= '1;
      mosi_sy <= '0;
    end else begin
      sclk_sy <= {sclk_sy[1:0], sclk};
      ss_sy   <= {ss_sy[1:0], ss_n};
      mosi_sy <= {mosi_sy[0], mosi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      in_sr    <= '0;
      out_sr   <= '0;
      wdata    <= '0;
      byte_idx <= '0;
      is_wr    <= 1'b0;
      wr_q     <= 1'b0;
      rd_q     <= 1'b0;
      rd_dly   <= 1'b0;
      addr     <= '0;
    end else begin
      wr_q   <= 1'b0;
      rd_q   <= 1'b0;
      rd_dly <= rd_q;
      if (!active) begin
        bit_cnt  <= '0;
        byte_idx <= '0;
        out_sr   <= '0;
        rd_dly   <= 1'b0;
      end else begin
        if (sclk_rise) begin
          bit_cnt <= bit_cnt + 3'd1;
          in_sr   <= rx[6:0];
        end
        if (sclk_fall && bit_cnt != 3'd0)
          out_sr <= {out_sr[6:0], 1'b0};
        if (byte_done) begin
          case (byte_idx)
            2'd0: begin
              is_wr        <= rx[7];
              addr[HDR_AW-1:8] <= rx[HDR_AW-9:0];
              byte_idx     <= 2'd1;
            end
            2'd1: begin
              addr[7:0] <= rx;
              byte_idx  <= 2'd2;
              rd_q      <= ~is_wr;
            end
            default: begin
              if (is_wr) begin
                wdata <= rx;
                wr_q  <= 1'b1;
              end else begin
                addr <= addr + 1'b1;
                rd_q <= 1'b1;
              end
            end
          endcase
        end
        if (wr_q)
          addr <= addr + 1'b1;
        if (rd_dly)
          out_sr <= in_usr ? usr_rdata : loc_rdata;
      end
    end
  end

  assign miso      = out_sr[7];
  assign loc_wr    = wr_q & ~in_usr;
  assign usr_wr    = wr_q & in_usr;
  assign loc_rd    = rd_q & ~in_usr;
  assign usr_rd    = rd_q & in_usr;
  assign loc_addr  = 8'(addr[LOC_AW-1:0]);
  assign usr_addr  = addr - BASE;
  assign loc_wdata = wdata;
  assign usr_wdata = wdata;
endmodule

// File: rtl/spi_mm_bridge_chk.sv
module spi_mm_bridge_chk #(
  parameter int HDR_AW = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              active,
  input logic              miso,
  input logic              is_wr,
  input logic              loc_wr,
  input logic              loc_rd,
  input logic              usr_wr,
  input logic              usr_rd,
  input logic [HDR_AW-1:0] addr
);
  wire any_wr = loc_wr | usr_wr;
  wire any_st = any_wr | loc_rd | usr_rd;

  assert_one_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({loc_wr, loc_rd, usr_wr, usr_rd}));

  assert_wr_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    any_wr |=> !any_wr);

  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    any_wr |=> addr == HDR_AW'($past(addr) + 1'b1));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !active && !$past(active) |-> !any_st);

  assert_miso_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    is_wr && $stable(is_wr) |-> !miso);
endmodule

bind spi_mm_bridge spi_mm_bridge_chk #(.HDR_AW(HDR_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .active(active), .miso(miso), .is_wr(is_wr),
  .loc_wr(loc_wr), .loc_rd(loc_rd), .usr_wr(usr_wr), .usr_rd(usr_rd),
  .addr(addr)
);

// File: tb/tb_spi_mm_bridge.sv
`timescale 1ns/1ps
module tb_spi_mm_bridge;
  logic clk = 0, rst_n = 0;
  logic sclk = 0, mosi = 0, ss_n = 1;
  logic miso, loc_wr, loc_rd, usr_wr, usr_rd;
  logic [7:0] loc_addr, loc_wdata, usr_wdata;
  logic [7:0] loc_rdata, usr_rdata;
  logic [14:0] usr_addr;

  always #2.5 clk = ~clk;

  spi_mm_bridge dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .ss_n(ss_n), .miso(miso),
    .loc_wr(loc_wr), .loc_rd(loc_rd), .loc_addr(loc_addr), .loc_wdata(loc_wdata),
    .loc_rdata(loc_rdata), .usr_wr(usr_wr), .usr_rd(usr_rd), .usr_addr(usr_addr),
    .usr_wdata(usr_wdata), .usr_rdata(usr_rdata)
  );

  logic [7:0] m_loc [256];
  logic [7:0] m_usr [256];
  logic [7:0] e_loc [256];
  logic [7:0] e_usr [256];
  int n_wr = 0, n_rd = 0, n_bad_usr = 0;
  int tests = 0, fails = 0;

  function automatic logic [7:0] init_val(input int i, input int r);
    return 8'(i * 7 + 3 + r * 91);
  endfunction

  function automatic logic [7:0] exp_at(input int a);
    return (a < 256) ? e_loc[a] : e_usr[a - 256];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) begin
        m_loc[i] <= init_val(i, 0);
        m_usr[i] <= init_val(i, 1);
      end
      loc_rdata <= 0;
      usr_rdata <= 0;
    end else begin
      if (loc_wr) m_loc[loc_addr] <= loc_wdata;
      if (usr_wr) begin
        if (usr_addr > 15'd255) n_bad_usr <= n_bad_usr + 1;
        m_usr[usr_addr[7:0]] <= usr_wdata;
      end
      if (loc_rd) loc_rdata <= m_loc[loc_addr];
      if (usr_rd) usr_rdata <= m_usr[usr_addr[7:0]];
      if (loc_wr || usr_wr) n_wr <= n_wr + 1;
      if (loc_rd || usr_rd) n_rd <= n_rd + 1;
    end
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = 0;
    for (int i = 7; i > 7 - nbits; i--) begin
      mosi = tx[i];
      clks(8);
      sclk = 1;
      rx[i] = miso;
      clks(8);
      sclk = 0;
    end
  endtask

  task automatic frame(input logic wr, input int a, input int len, input logic [7:0] d [8],
                       output logic [7:0] q [8]);
    logic [7:0] r;
    logic [15:0] hdr;
    hdr = {wr, 15'(a)};
    ss_n = 0;
    clks(8);
    xfer(hdr[15:8], 8, r);
    check(r == 0, "R10", r, 0);
    xfer(hdr[7:0], 8, r);
    for (int k = 0; k < len; k++) begin
      xfer(d[k], 8, r);
      q[k] = r;
    end
    clks(8);
    ss_n = 1;
    clks(16);
  endtask

  task automatic mem_cmp(input string req);
    int bad = 0;
    for (int i = 0; i < 256; i++) begin
      if (m_loc[i] !== e_loc[i]) bad++;
      if (m_usr[i] !== e_usr[i]) bad++;
    end
    check(bad == 0 && n_bad_usr == 0, req, bad + n_bad_usr, 0);
  endtask

  task automatic do_write(input int a, input int len, input logic [7:0] d [8], input string req);
    logic [7:0] q [8];
    int w0;
    w0 = n_wr;
    frame(1'b1, a, len, d, q);
    for (int k = 0; k < len; k++) begin
      if (a + k < 256) e_loc[a + k] = d[k]; else e_usr[a + k - 256] = d[k];
      check(q[k] == 0, "R10", q[k], 0);
    end
    check(n_wr - w0 == len, "R5", n_wr - w0, len);
    mem_cmp(req);
  endtask

  task automatic do_read(input int a, input int len, input string req);
    logic [7:0] d [8];
    logic [7:0] q [8];
    int r0;
    for (int k = 0; k < 8; k++) d[k] = 8'($urandom);
    r0 = n_rd;
    frame(1'b0, a, len, d, q);
    for (int k = 0; k < len; k++)
      check(q[k] == exp_at(a + k), req, q[k], exp_at(a + k));
    check(n_rd - r0 == len + 1, "R8", n_rd - r0, len + 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] d [8];
    logic [7:0] r;
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) begin
      e_loc[i] = init_val(i, 0);
      e_usr[i] = init_val(i, 1);
    end
    clks(5);
    rst_n = 1;
    clks(4);
    check(miso == 0 && !loc_wr && !loc_rd && !usr_wr && !usr_rd, "R10", miso, 0);
    check(n_wr == 0 && n_rd == 0, "R10", n_wr + n_rd, 0);

    // R3: local write and read back
    for (int k = 0; k < 8; k++) d[k] = 8'(8'hA0 + k);
    do_write(8'h10, 3, d, "R3");
    do_read(8'h10, 3, "R3");
    // R4: user region, offset removed
    for (int k = 0; k < 8; k++) d[k] = 8'(8'h50 + k);
    do_write(16'h180, 2, d, "R4");
    do_read(16'h180, 2, "R4");
    // R6: crossing the 0x0FF/0x100 boundary
    for (int k = 0; k < 8; k++) d[k] = 8'(8'hC0 + k);
    do_write(8'hFE, 4, d, "R6");
    do_read(8'hFD, 5, "R6");
    // R7: single-byte read at the first location of each region
    do_read(0, 1, "R7");
    do_read(16'h100, 1, "R7");
    // R2: header with bit 15 clear never writes
    begin
      logic [7:0] q [8];
      int w0;
      w0 = n_wr;
      for (int k = 0; k < 8; k++) d[k] = 8'hEE;
      frame(1'b0, 8'h20, 3, d, q);
      check(n_wr == w0, "R2", n_wr - w0, 0);
      mem_cmp("R2");
    end
    // R1: aborted frames: partial header, then partial payload byte
    begin
      int w0;
      int r0;
      w0 = n_wr;
      r0 = n_rd;
      ss_n = 0; clks(8);
      xfer(8'h80, 8, r);
      xfer(8'h30, 5, r);
      clks(8); ss_n = 1; clks(16);
      ss_n = 0; clks(8);
      xfer(8'h80, 8, r);
      xfer(8'h31, 8, r);
      xfer(8'h99, 6, r);
      clks(8); ss_n = 1; clks(16);
      check(n_wr == w0 && n_rd == r0, "R1", n_wr - w0 + n_rd - r0, 0);
      mem_cmp("R1");
      for (int k = 0; k < 8; k++) d[k] = 8'h5A;
      do_write(8'h31, 1, d, "R1");
    end

    // random frames
    for (int t = 0; t < 40; t++) begin
      int a;
      int len;
      a = int'($urandom_range(0, 508));
      len = int'($urandom_range(1, 3));
      for (int k = 0; k < 8; k++) d[k] = 8'($urandom);
      if ($urandom_range(0, 1) == 1) do_write(a, len, d, (a + len > 256) ? "R4" : "R5");
      else do_read(a, len, "R8");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule